// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is a single-lane SPI master that a processor drives through three word registers on a simple read/write bus: a control/status word, a clock divider and a byte queue port. Software picks a chip select, clock polarity and phase, then sets the run flag. While the run flag is set, bytes written to the queue port are shifted out on MOSI, most significant bit first. Bytes captured from MISO at the same time land in a receive queue that software drains through the same port.

Each of the three chip-select lines has its own active level. The SCLK rate is the core clock divided by an even divisor. An interrupt line combines two conditions, each with its own enable: "all queued bytes have gone out" and "the receive queue is nearly full". When the receive queue fills, the shifter pauses until software makes room, so no received byte is ever lost.

Top module: `spi_host_regs`

Bus addresses (`bus_addr`): 0 is control/status, 1 is the byte queue, 2 is the divider.

## Requirements
- R1: Control/status word layout. Read/write fields: [1:0] chip-select number, [2] phase (CPHA), [3] polarity (CPOL), [6] global polarity flag (stored only), [7] run flag, [9] done-interrupt enable, [10] rx-level interrupt enable, [12] read-enable flag (stored only), and [21], [22], [23] the active levels of chip selects 0, 1, 2 (1 = active high). Read-only fields: [16] done, [17] rx has data, [18] tx has room, [19] rx at threshold, [20] rx full. Bits [4], [5], [8], [11], [13] read back as 0. The divider register keeps bits [15:0] of the written word.
- R2: One SCLK half period lasts D/2 core cycles. D is the divider value with bit 0 forced to 0. A D of 0, which comes from writing 0 or 1, gives a half period of 32768 cycles.
- R3: A write to the queue port adds a byte to the 16-entry transmit queue only while the run flag is set and the queue is not full. Any other such write is dropped.
- R4: Transfers are full duplex and MSB first. Each transmitted byte yields one received byte, and the receive queue hands bytes back in arrival order in read-data bits [7:0].
- R5: All four modes work. With CPHA=0, data is sampled on the leading SCLK edge and the first bit is on MOSI before that edge. With CPHA=1, data changes on the leading edge and is sampled on the trailing edge.
- R6: While the run flag is set and the chip-select number n is 0 to 2, line n sits at its active level. Every other line, all lines while the run flag is clear, and all lines for number 3 sit inactive.
- R7: Whenever no byte is being shifted, SCLK rests at the CPOL level.
- R8: Writing 1 to control bit [4] empties the transmit queue; writing 1 to bit [5] empties the receive queue.
- R9: Done = run flag set, transmit queue empty and shifter idle. irq = (bit 9 and done) or (bit 10 and rx-at-threshold). Setting the run flag with an empty queue and bit 9 set raises irq on the next cycle.
- R10: Rx-at-threshold asserts at 12 or more stored bytes and rx-full at 16. While the receive queue is full, no new byte starts.
- R11: Clearing the run flag aborts any byte in flight, returns SCLK to its rest level and removes the done term from irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe; a read of address 1 pops the receive queue |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs | output | 3 | Chip-select lines, each at its own active level |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of events can land in the same cycle. The shifter can push a finished byte into the receive queue while software pops it, and software can push the transmit queue while the shifter loads its next byte from it. The bench provokes both by streaming bytes at the fastest divider while it polls status and alternately pushes and pops on every bus slot. It judges the result by exact byte order on both sides of the link, together with the queue-level status bits at the threshold, full and stall points.

// File: rtl/spi_host_regs.sv
module spi_host_regs #(
  parameter int DEPTH     = 16,
  parameter int RXR_LEVEL = 12,
  parameter int DIVW      = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  bus_addr,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  input  logic        bus_rd,
  output logic [31:0] bus_rdata,
  output logic        spi_sclk,
  output logic        spi_mosi,
  input  logic        spi_miso,
  output logic [2:0]  spi_cs,
  output logic        irq
);
  localparam int PW = $clog2(DEPTH);
  localparam logic [PW:0] CNT_FULL = (PW+1)'(DEPTH);
  localparam logic [PW:0] CNT_RXR  = (PW+1)'(RXR_LEVEL);
  localparam logic [1:0] A_CTL = 2'd0, A_FIFO = 2'd1, A_DIV = 2'd2;

  logic [1:0] csel;
  logic cpha, cpol, gpol, ta, intd, intr, ren;
  logic [2:0] cspol;
  logic [DIVW-1:0] div_q;

  logic wr_ctl, clr_tx, clr_rx;
  assign wr_ctl = bus_wr && bus_addr == A_CTL;
  assign clr_tx = wr_ctl && bus_wdata[4];
  assign clr_rx = wr_ctl && bus_wdata[5];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      csel <= '0; cpha <= 1'b0; cpol <= 1'b0; gpol <= 1'b0; ta <= 1'b0;
      intd <= 1'b0; intr <= 1'b0; ren <= 1'b0; cspol <= '0;
    end else if (wr_ctl) begin
      csel  <= bus_wdata[1:0];
      cpha  <= bus_wdata[2];
      cpol  <= bus_wdata[3];
      gpol  <= bus_wdata[6];
      ta    <= bus_wdata[7];
      intd  <= bus_wdata[9];
      intr  <= bus_wdata[10];
      ren   <= bus_wdata[12];
      cspol <= bus_wdata[23:21];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) div_q <= '0;
    else if (bus_wr && bus_addr == A_DIV) div_q <= bus_wdata[DIVW-1:0];

  logic unused_wbits;
  assign unused_wbits = ^{bus_wdata[31:24], bus_wdata[20:13], bus_wdata[11], bus_wdata[8]};

  // transmit queue
  logic [7:0] tx_mem [DEPTH];
  logic [PW:0] tx_w, tx_r, tx_cnt;
  logic tx_full, tx_push, start;
  assign tx_cnt  = tx_w - tx_r;
  assign tx_full = tx_cnt == CNT_FULL;
  assign tx_push = bus_wr && bus_addr == A_FIFO && ta && !tx_full;

  always_ff @(posedge clk)
    if (tx_push) tx_mem[tx_w[PW-1:0]] <= bus_wdata[7:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_w <= '0; tx_r <= '0;
    end else begin
      if (tx_push) tx_w <= tx_w + 1'b1;
      if (clr_tx) tx_r <= tx_w;
      else if (start) tx_r <= tx_r + 1'b1;
    end

  // receive queue
  logic [7:0] rx_mem [DEPTH];
  logic [PW:0] rx_w, rx_r, rx_cnt;
  logic rx_full, rx_pop, byte_done;
  logic [7:0] rx_byte;
  assign rx_cnt  = rx_w - rx_r;
  assign rx_full = rx_cnt == CNT_FULL;
  assign rx_pop  = bus_rd && bus_addr == A_FIFO && rx_cnt != '0;

  always_ff @(posedge clk)
    if (byte_done) rx_mem[rx_w[PW-1:0]] <= rx_byte;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_w <= '0; rx_r <= '0;
    end else if (clr_rx) begin
      rx_w <= '0; rx_r <= '0;
    end else begin
      if (byte_done) rx_w <= rx_w + 1'b1;
      if (rx_pop) rx_r <= rx_r + 1'b1;
    end

  // shift engine
  logic busy, phase;
  logic [DIVW-1:0] hc, half;
  logic [3:0] ec;
  logic [7:0] tx_sh, rx_sh;
  logic edge_now, samp_edge;

  assign half      = (div_q[DIVW-1:1] == '0) ? {1'b1, {(DIVW-1){1'b0}}} : {1'b0, div_q[DIVW-1:1]};
  assign edge_now  = busy && hc == half - 1'b1;
  assign samp_edge = ec[0] == cpha;
  assign start     = ta && !busy && tx_cnt != '0 && !rx_full;
  assign byte_done = ta && edge_now && ec == 4'd15;
  assign rx_byte   = cpha ? {rx_sh[6:0], spi_miso} : rx_sh;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy <= 1'b0; phase <= 1'b0; hc <= '0; ec <= '0; tx_sh <= '0; rx_sh <= '0;
    end else if (!ta) begin
      busy <= 1'b0; phase <= 1'b0; hc <= '0; ec <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      tx_sh <= tx_mem[tx_r[PW-1:0]];
      hc    <= '0;
      ec    <= '0;
    end else if (edge_now) begin
      hc    <= '0;
      phase <= ~phase;
      ec    <= ec + 1'b1;
      if (samp_edge) rx_sh <= {rx_sh[6:0], spi_miso};
      else if (!(cpha && ec == 4'd0)) tx_sh <= {tx_sh[6:0], 1'b0};
      if (ec == 4'd15) busy <= 1'b0;
    end else if (busy) begin
      hc <= hc + 1'b1;
    end

  assign spi_sclk = cpol ^ phase;
  assign spi_mosi = tx_sh[7];

  for (genvar i = 0; i < 3; i++) begin : g_cs
    assign spi_cs[i] = (ta && csel == 2'(i)) ? cspol[i] : ~cspol[i];
  end

  // status and interrupt
  logic st_done, st_rxd, st_txd, st_rxr, st_rxf;
  assign st_done = ta && tx_cnt == '0 && !busy;
  assign st_rxd  = rx_cnt != '0;
  assign st_txd  = !tx_full;
  assign st_rxr  = rx_cnt >= CNT_RXR;
  assign st_rxf  = rx_full;
  assign irq     = (intd && st_done) || (intr && st_rxr);

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTL: begin
        bus_rdata[1:0]   = csel;
        bus_rdata[2]     = cpha;
        bus_rdata[3]     = cpol;
        bus_rdata[6]     = gpol;
        bus_rdata[7]     = ta;
        bus_rdata[9]     = intd;
        bus_rdata[10]    = intr;
        bus_rdata[12]    = ren;
        bus_rdata[16]    = st_done;
        bus_rdata[17]    = st_rxd;
        bus_rdata[18]    = st_txd;
        bus_rdata[19]    = st_rxr;
        bus_rdata[20]    = st_rxf;
        bus_rdata[23:21] = cspol;
      end
      A_FIFO:  bus_rdata[7:0] = rx_mem[rx_r[PW-1:0]];
      A_DIV:   bus_rdata[DIVW-1:0] = div_q;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_host_regs_chk.sv
module spi_host_regs_chk #(
  parameter int DEPTH = 16,
  parameter int PW    = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        ta,
  input logic        busy,
  input logic        cpol,
  input logic        intd,
  input logic        spi_sclk,
  input logic [2:0]  spi_cs,
  input logic [2:0]  cspol,
  input logic [PW:0] tx_cnt,
  input logic [PW:0] rx_cnt,
  input logic        irq
);
  p_cs_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ta |-> spi_cs == ~cspol);

  p_one_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(spi_cs ^ ~cspol));

  p_sclk_rest_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> spi_sclk == cpol);

  p_sclk_moves_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(spi_sclk) && $stable(cpol)) |-> $past(busy));

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= (PW+1)'(DEPTH) && rx_cnt <= (PW+1)'(DEPTH));

  p_done_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ta && intd && tx_cnt == '0 && !busy) |-> irq);

  p_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !ta |=> !busy);
endmodule

bind spi_host_regs spi_host_regs_chk #(.DEPTH(DEPTH), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ta(ta), .busy(busy), .cpol(cpol), .intd(intd),
  .spi_sclk(spi_sclk), .spi_cs(spi_cs), .cspol(cspol),
  .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .irq(irq)
);

// File: tb/spi_host_regs_tb.sv
module spi_host_regs_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic spi_sclk, spi_mosi, spi_miso, irq;
  logic [2:0] spi_cs;

  always #2 clk = ~clk;

  spi_host_regs u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .spi_cs(spi_cs), .irq(irq)
  );

  localparam logic [31:0] TA = 32'h80, INTD = 32'h200, INTR = 32'h400;
  localparam logic [31:0] CLRT = 32'h10, CLRR = 32'h20;

  int vecs = 0, errs = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] sbyte(input int k);
    return 8'((k * 53 + 17) & 255);
  endfunction
  function automatic logic [7:0] mbyte(input int k);
    return 8'((k * 29 + 200) & 255);
  endfunction

  // slave model
  logic [1:0] cur_cs = 2'd3;
  logic [2:0] cur_pol = 3'b000;
  logic m_cpha = 1'b0;
  int s_e = 0, s_idx = 0, s_base = 0, r_cnt = 0;
  logic [7:0] s_sh = 8'h00, s_rx = 8'h00;
  logic [7:0] r_log [64];
  logic s_samp;
  wire act = (cur_cs != 2'd3) && (spi_cs[cur_cs] == cur_pol[cur_cs]);
  assign spi_miso = s_sh[7];

  always @(posedge act) begin
    s_e = 0; s_base = s_idx; s_sh = sbyte(s_idx); s_idx++; r_cnt = 0; s_rx = 8'h00;
  end

  always @(spi_sclk) begin
    if (act) begin
      s_samp = ((s_e % 2) == int'(m_cpha));
      if (s_samp) s_rx = {s_rx[6:0], spi_mosi};
      else if (!(m_cpha && s_e == 0)) s_sh = {s_sh[6:0], 1'b0};
      if (s_e == 15) begin
        if (r_cnt < 64) r_log[r_cnt] = s_rx;
        r_cnt++;
        s_sh = sbyte(s_idx); s_idx++; s_e = 0;
      end else s_e++;
    end
  end

  task automatic bw(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1 bus_wr = 1'b0;
  endtask

  task automatic br(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1; #1 d = bus_rdata;
    @(posedge clk); #1 bus_rd = 1'b0;
  endtask

  function automatic logic [31:0] cw(input int mode, input int cs, input logic [2:0] pol);
    return 32'(cs) | (mode[0] ? 32'h4 : 32'h0) | (mode[1] ? 32'h8 : 32'h0) | {8'h0, pol, 21'h0};
  endfunction

  function automatic logic [2:0] cs_exp(input int cs, input logic [2:0] pol, input bit run);
    logic [2:0] e = ~pol;
    if (run && cs < 3) e[cs] = pol[cs];
    return e;
  endfunction

  int mk = 0;

  task automatic xfer(input int n, input int mode, input int cs, input logic [2:0] pol, input logic [15:0] dv);
    logic [31:0] st, d, base;
    int sent = 0, got = 0, guard = 0;
    base = 32'(mk);
    bw(0, cw(mode, cs, pol) | CLRT | CLRR);
    cur_cs = 2'(cs); cur_pol = pol; m_cpha = mode[0];
    bw(2, {16'h0, dv});
    chk($sformatf("R7 rest level mode %0d", mode), {31'h0, spi_sclk}, {31'h0, mode[1]});
    chk($sformatf("R6 cs idle mode %0d cs %0d", mode, cs), {29'h0, spi_cs}, {29'h0, cs_exp(cs, pol, 0)});
    bw(0, cw(mode, cs, pol) | TA | INTD);
    chk($sformatf("R6 cs active mode %0d cs %0d", mode, cs), {29'h0, spi_cs}, {29'h0, cs_exp(cs, pol, 1)});
    while (got < n && guard < 4000) begin
      guard++;
      br(0, st);
      if (sent < n && st[18]) begin
        bw(1, {24'h0, mbyte(mk + sent)}); sent++;
      end else if (st[17]) begin
        br(1, d);
        chk($sformatf("R4 R5 rx byte %0d mode %0d", got, mode), d, {24'h0, sbyte(s_base + got)});
        got++;
      end
    end
    br(0, st);
    chk($sformatf("R9 done mode %0d", mode), {31'h0, st[16]}, 32'h1);
    chk($sformatf("R9 irq done mode %0d", mode), {31'h0, irq}, 32'h1);
    for (int j = 0; j < n; j++)
      chk($sformatf("R5 slave got byte %0d mode %0d", j, mode), {24'h0, r_log[j]}, {24'h0, mbyte(int'(base) + j)});
    mk += n;
    bw(0, cw(mode, cs, pol));
    chk($sformatf("R7 rest after mode %0d", mode), {31'h0, spi_sclk}, {31'h0, mode[1]});
  endtask

  task automatic divchk(input logic [15:0] v);
    int n = 0;
    logic p;
    logic [15:0] d = v & 16'hFFFE;
    int exp = (d == 0) ? 32768 : int'(d) / 2;
    bw(0, CLRT | CLRR);
    cur_cs = 2'd0; cur_pol = 3'b000; m_cpha = 1'b0;
    bw(2, {16'h0, v});
    bw(0, TA);
    bw(1, 32'hA5);
    p = spi_sclk;
    while (spi_sclk == p && n < 70000) begin @(negedge clk); n++; end
    n = 0; p = spi_sclk;
    while (spi_sclk == p && n < 70000) begin @(negedge clk); n++; end
    chk($sformatf("R2 half period div %0d", v), 32'(n), 32'(exp));
    bw(0, 32'h0);
    @(negedge clk); @(negedge clk);
    chk("R11 sclk rest after abort", {31'h0, spi_sclk}, 32'h0);
    chk("R11 irq silent after abort", {31'h0, irq}, 32'h0);
  endtask

  task automatic report;
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual=running expected=finished");
    report();
  end

  initial begin
    logic [31:0] st, d;
    int base;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    br(0, st);
    chk("R1 reset control word", st, 32'h0004_0000);
    chk("R9 reset irq", {31'h0, irq}, 32'h0);
    chk("R6 reset cs", {29'h0, spi_cs}, 32'h7);

    // R1 layout
    bw(0, 32'hFFFF_FFFF);
    br(0, st);
    chk("R1 all-ones readback", st, 32'h00E5_16CF);
    chk("R6 select 3 none active", {29'h0, spi_cs}, 32'h0);
    chk("R9 irq on run with empty queue", {31'h0, irq}, 32'h1);
    bw(0, 32'h0);
    br(0, st);
    chk("R1 cleared readback", st, 32'h0004_0000);
    bw(2, 32'h0001_2345);
    br(2, d);
    chk("R1 divider readback", d, 32'h0000_2345);

    // R3 writes dropped while idle
    bw(0, CLRT | CLRR);
    bw(1, 32'h11); bw(1, 32'h22); bw(1, 32'h33);
    bw(0, TA | INTD);
    @(negedge clk);
    chk("R9 irq right after run set", {31'h0, irq}, 32'h1);
    br(0, st);
    chk("R3 done with dropped pushes", {31'h0, st[16]}, 32'h1);
    repeat (20) @(negedge clk);
    br(0, st);
    chk("R3 nothing shifted", {31'h0, st[17]}, 32'h0);
    bw(0, 32'h0);

    // R5 sweep over modes, selects and polarities
    for (int m = 0; m < 4; m++)
      for (int c = 0; c < 3; c++)
        xfer(3, m, c, 3'((m * 3 + c + 1) & 7), 16'(2 + 2 * c + (m & 1)));

    // R3 R8 transmit queue full and clear
    bw(0, CLRT | CLRR);
    cur_cs = 2'd0; cur_pol = 3'b000; m_cpha = 1'b0;
    bw(2, 32'h0);
    bw(0, TA);
    for (int i = 0; i < 20; i++) bw(1, 32'(i));
    br(0, st);
    chk("R3 tx full no room", {31'h0, st[18]}, 32'h0);
    bw(0, TA | CLRT);
    br(0, st);
    chk("R8 tx cleared has room", {31'h0, st[18]}, 32'h1);
    bw(0, 32'h0);

    // R10 receive levels and stall
    bw(0, CLRT | CLRR);
    bw(2, 32'h2);
    bw(0, TA | INTR);
    base = s_base;
    for (int i = 0; i < 16; i++) bw(1, {24'h0, mbyte(mk + i)});
    repeat (400) @(negedge clk);
    br(0, st);
    chk("R10 rx full", {31'h0, st[20]}, 32'h1);
    chk("R10 rx threshold", {31'h0, st[19]}, 32'h1);
    chk("R9 irq from rx level", {31'h0, irq}, 32'h1);
    for (int i = 0; i < 4; i++) begin
      br(1, d); chk($sformatf("R4 rx order %0d", i), d, {24'h0, sbyte(base + i)});
    end
    br(0, st);
    chk("R10 threshold at 12", {31'h0, st[19]}, 32'h1);
    br(1, d); chk("R4 rx order 4", d, {24'h0, sbyte(base + 4)});
    br(0, st);
    chk("R10 threshold off at 11", {31'h0, st[19]}, 32'h0);
    chk("R9 irq off at 11", {31'h0, irq}, 32'h0);
    for (int i = 16; i < 22; i++) bw(1, {24'h0, mbyte(mk + i)});
    repeat (300) @(negedge clk);
    br(0, st);
    chk("R10 stalled not done", {31'h0, st[16]}, 32'h0);
    chk("R10 stalled full", {31'h0, st[20]}, 32'h1);
    for (int i = 5; i < 21; i++) begin
      br(1, d); chk($sformatf("R4 rx order %0d", i), d, {24'h0, sbyte(base + i)});
    end
    repeat (60) @(negedge clk);
    br(0, st);
    chk("R10 resumed done", {31'h0, st[16]}, 32'h1);
    br(1, d); chk("R4 rx order 21", d, {24'h0, sbyte(base + 21)});
    for (int j = 0; j < 22; j++)
      chk($sformatf("R4 slave got %0d", j), {24'h0, r_log[j]}, {24'h0, mbyte(mk + j)});
    mk += 22;
    bw(1, 32'h5A); bw(1, 32'hC3);
    repeat (80) @(negedge clk);
    br(0, st);
    chk("R8 rx holds data", {31'h0, st[17]}, 32'h1);
    bw(0, TA | INTR | CLRR);
    br(0, st);
    chk("R8 rx emptied", {31'h0, st[17]}, 32'h0);
    bw(0, 32'h0);
    mk += 2;

    // R2 divider rules
    divchk(16'd2);
    divchk(16'd3);
    divchk(16'd10);
    divchk(16'd7);
    divchk(16'd0);
    divchk(16'd1);

    report();
  end
endmodule